// File: doc/BRIEF.md
# Dual-Threshold Pulse Trigger with Pulse-Area Window

This block watches a continuous stream of unsigned 12-bit converter samples, one on every clock, and never applies backpressure to that stream. It keeps the sum of the 25 most recent samples in a register. It also holds the samples in a 25-entry delay line, so that when a sample reaches the last tap, the sum covers exactly that sample and the 24 samples that arrived after it. A pulse is declared when the sample at the last tap is at or above a low threshold and the sample that followed it is at or above a higher threshold. The low threshold sits just above the noise floor and catches the first sample of a pulse. The high threshold rejects noise that crossed only the low one.

Each detection yields one 32-bit record. The low half holds the first pulse sample and the high half holds the pulse area. The record is offered on a valid/ready port. If the port is still occupied when a new detection arrives, the new record is discarded and a sticky overflow flag is raised.

A three-state controller orders the work. FILL counts the first 25 samples after reset until the delay line holds real data, and then moves to ARMED. ARMED compares the two taps with the thresholds on every clock and moves to HOLD on a detection. HOLD counts 24 further samples and then returns to ARMED, so that two accepted pulses cannot overlap.

Top module: `pulse_trigger`

## Requirements
- R1: The reported area is the unsigned sum of the first pulse sample and the 24 samples that followed it, which is 25 consecutive input samples.
- R2: A detection occurs when the first sample is at or above `thr_first` and the next input sample is at or above `thr_second`. Both comparisons are unsigned, and equality passes.
- R3: If either comparison fails, no record is produced for that sample pair.
- R4: The first samples of two detections are at least 25 input samples apart. After a detection, the next one can come no sooner than 25 clocks later.
- R5: `ev_data[15:0]` holds the first sample, zero-extended. `ev_data[31:16]` holds the area, which saturates at 0xFFFF when the true sum exceeds 65535.
- R6: While `ev_valid` is high and `ev_ready` is low, `ev_valid` stays high and `ev_data` does not change.
- R7: A detection that arrives while `ev_valid` is high and `ev_ready` is low is discarded. The held record is kept and `ev_overflow` is set. `ev_overflow` stays set until reset.
- R8: A synchronous reset clears the sum, the delay line, the controller, `ev_valid` and `ev_overflow`. No record appears within the first 25 clocks after reset.
- R9: A record is offered on the cycle after the clock edge on which the tested first sample reaches the last delay tap. With all-zero thresholds and a zero input, the first `ev_valid` therefore appears right after the 26th clock edge after reset, and it carries area 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample is taken per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | 12 | Unsigned converter sample |
| thr_first | input | 12 | Low threshold, applied to the candidate first sample |
| thr_second | input | 12 | High threshold, applied to the sample after it |
| ev_valid | output | 1 | A detection record is on offer |
| ev_ready | input | 1 | The consumer accepts the record on this edge |
| ev_data | output | 32 | {area[15:0], first sample zero-extended to 16 bits} |
| ev_overflow | output | 1 | Sticky flag: a detection was discarded |

## Verification
The bench places samples exactly on each threshold and one step below it. An off-by-one comparison would then either drop an edge-case pulse or accept a sub-threshold one. It drives a full-scale pulse whose 25-sample sum overflows the 16-bit field, which catches a wrap-around in place of saturation. With all-zero thresholds, it measures the cycle of the first record after reset and the spacing between later records. A miscounted fill or hold window would move those records by a cycle. The bench also loads samples before a reset and checks that the first area after the reset is zero. Finally, it stalls the consumer across two pulses and checks that the first record survives, that the second is lost and that the overflow flag stays set.

// File: rtl/pt_pkg.sv
package pt_pkg;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HOLD  = 2'd2
    } trig_state_e;

    function automatic int sum_width(input int sample_w, input int len);
        return sample_w + $clog2(len + 1);
    endfunction

endpackage

// File: rtl/pt_window.sv
module pt_window #(
    parameter int SAMPLE_W = 12,
    parameter int LEN      = 25,
    parameter int SUM_W    = pt_pkg::sum_width(SAMPLE_W, LEN)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] smp_in,
    output logic [SAMPLE_W-1:0] tap_first,
    output logic [SAMPLE_W-1:0] tap_second,
    output logic [SUM_W-1:0]    area
);
    logic [SAMPLE_W-1:0] tap_q [LEN];
    logic [SUM_W-1:0]    acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LEN; i++) tap_q[i] <= '0;
            acc_q <= '0;
        end else begin
            tap_q[0] <= smp_in;
            for (int i = 1; i < LEN; i++) tap_q[i] <= tap_q[i-1];
            acc_q <= acc_q + SUM_W'(smp_in) - SUM_W'(tap_q[LEN-1]);
        end
    end

    assign tap_first  = tap_q[LEN-1];
    assign tap_second = tap_q[LEN-2];
    assign area       = acc_q;
endmodule

// File: rtl/pt_pack.sv
module pt_pack #(
    parameter int SAMPLE_W = 12,
    parameter int SUM_W    = 17,
    parameter int FIELD_W  = 16
) (
    input  logic [SAMPLE_W-1:0]  first_smp,
    input  logic [SUM_W-1:0]     area,
    output logic [2*FIELD_W-1:0] word
);
    logic [FIELD_W-1:0] area_f;

    generate
        if (SUM_W > FIELD_W) begin : g_sat
            always_comb begin
                if (area > SUM_W'({FIELD_W{1'b1}})) area_f = '1;
                else                                area_f = area[FIELD_W-1:0];
            end
        end else begin : g_fit
            assign area_f = FIELD_W'(area);
        end
    endgenerate

    assign word = {area_f, FIELD_W'(first_smp)};
endmodule

// File: rtl/pulse_trigger.sv
module pulse_trigger #(
    parameter int SAMPLE_W = 12,
    parameter int LEN      = 25,
    parameter int FIELD_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SAMPLE_W-1:0]  smp_in,
    input  logic [SAMPLE_W-1:0]  thr_first,
    input  logic [SAMPLE_W-1:0]  thr_second,
    output logic                 ev_valid,
    input  logic                 ev_ready,
    output logic [2*FIELD_W-1:0] ev_data,
    output logic                 ev_overflow
);
    import pt_pkg::*;

    localparam int SUM_W = sum_width(SAMPLE_W, LEN);
    localparam int CNT_W = $clog2(LEN);

    logic [SAMPLE_W-1:0]  tap_first, tap_second;
    logic [SUM_W-1:0]     area;
    logic [2*FIELD_W-1:0] packed_word;

    trig_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic hit;

    pt_window #(.SAMPLE_W(SAMPLE_W), .LEN(LEN), .SUM_W(SUM_W)) u_window (
        .clk(clk), .rst(rst), .smp_in(smp_in),
        .tap_first(tap_first), .tap_second(tap_second), .area(area)
    );

    pt_pack #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W), .FIELD_W(FIELD_W)) u_pack (
        .first_smp(tap_first), .area(area), .word(packed_word)
    );

    assign hit = (state_q == ST_ARMED) &&
                 (tap_first >= thr_first) && (tap_second >= thr_second);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_FILL: begin
                if (cnt_q == CNT_W'(LEN - 1)) begin
                    state_d = ST_ARMED;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_ARMED: begin
                if (hit) begin
                    state_d = ST_HOLD;
                    cnt_d   = CNT_W'(LEN - 2);
                end
            end
            ST_HOLD: begin
                if (cnt_q == '0) state_d = ST_ARMED;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: begin
                state_d = ST_FILL;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            ev_valid    <= 1'b0;
            ev_data     <= '0;
            ev_overflow <= 1'b0;
        end else begin
            if (hit && ev_valid && !ev_ready) ev_overflow <= 1'b1;
            if (hit && (!ev_valid || ev_ready)) begin
                ev_valid <= 1'b1;
                ev_data  <= packed_word;
            end else if (ev_ready) begin
                ev_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pulse_trigger_chk.sv
module pulse_trigger_chk #(
    parameter int SAMPLE_W = 12,
    parameter int LEN      = 25,
    parameter int FIELD_W  = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ev_valid,
    input logic                 ev_ready,
    input logic [2*FIELD_W-1:0] ev_data,
    input logic                 ev_overflow,
    input logic                 hit
);
    localparam int CW = $clog2(LEN + 2) + 1;

    logic [CW-1:0] since_rst, since_hit;
    logic          seen_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            since_hit <= '0;
            seen_hit  <= 1'b0;
        end else begin
            if (since_rst <= CW'(LEN)) since_rst <= since_rst + 1'b1;
            if (hit) begin
                since_hit <= '0;
                seen_hit  <= 1'b1;
            end else if (since_hit < CW'(LEN)) begin
                since_hit <= since_hit + 1'b1;
            end
        end
    end

    // R6
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_data)));

    // R7
    a_r7_sticky_overflow: assert property (@(posedge clk) disable iff (rst)
        ev_overflow |=> ev_overflow);

    // R7
    a_r7_overflow_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ev_overflow) |-> $past(hit && ev_valid && !ev_ready));

    // R4
    a_r4_hit_spacing: assert property (@(posedge clk) disable iff (rst)
        (hit && seen_hit) |-> (since_hit >= CW'(LEN - 1)));

    // R8
    a_r8_no_early_event: assert property (@(posedge clk) disable iff (rst)
        (since_rst <= CW'(LEN)) |-> !ev_valid);

    // R5
    a_r5_first_field_zero_ext: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> (ev_data[FIELD_W-1:SAMPLE_W] == '0));
endmodule

bind pulse_trigger pulse_trigger_chk #(
    .SAMPLE_W(SAMPLE_W), .LEN(LEN), .FIELD_W(FIELD_W)
) u_chk (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_data(ev_data), .ev_overflow(ev_overflow), .hit(hit)
);

// File: tb/pulse_trigger_bench.sv
module pulse_trigger_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] smp_in = '0;
    logic [11:0] thr_first = '0;
    logic [11:0] thr_second = '0;
    logic        ev_valid, ev_ready, ev_overflow;
    logic [31:0] ev_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    pulse_trigger u_pulse_trigger (
        .clk(clk), .rst(rst), .smp_in(smp_in), .thr_first(thr_first),
        .thr_second(thr_second), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_data(ev_data), .ev_overflow(ev_overflow)
    );

    typedef struct packed {
        logic [11:0] lo;
        logic [11:0] hi;
        logic [11:0] s0;
        logic [11:0] s1;
        logic [11:0] tail;
        logic        hit;
        logic [15:0] area;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{12'd20,   12'd200,  12'd50,   12'd300,  12'd100,  1'b1, 16'd2650},
        '{12'd20,   12'd200,  12'd50,   12'd150,  12'd10,   1'b0, 16'd0},
        '{12'd20,   12'd200,  12'd15,   12'd300,  12'd10,   1'b0, 16'd0},
        '{12'd20,   12'd200,  12'd20,   12'd200,  12'd5,    1'b1, 16'd335},
        '{12'd20,   12'd200,  12'd19,   12'd200,  12'd5,    1'b0, 16'd0},
        '{12'd20,   12'd200,  12'd4095, 12'd4095, 12'd4095, 1'b1, 16'hFFFF},
        '{12'd1000, 12'd3000, 12'd1500, 12'd3500, 12'd0,    1'b1, 16'd5000}
    };

    // handshake monitor, sampled mid-cycle
    int          ev_count = 0;
    logic [31:0] ev_last  = '0;
    always @(negedge clk) begin
        if (!rst && ev_valid && ev_ready) begin
            ev_count <= ev_count + 1;
            ev_last  <= ev_data;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic feed(input logic [11:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_in = v;
        end
    endtask

    task automatic pulse(input logic [11:0] s0, input logic [11:0] s1, input logic [11:0] tail);
        feed(s0, 1);
        feed(s1, 1);
        feed(tail, 23);
    endtask

    initial begin
        #(5ns * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        ev_ready = 1'b1;
        repeat (3) @(negedge clk);
        // reset state
        check(!ev_valid && !ev_overflow, "R8", "reset outputs",
              {30'd0, ev_valid, ev_overflow}, 32'd0);
        rst = 1'b0;

        // table walk: R1 R2 R3 R5
        for (int k = 0; k < NV; k++) begin
            thr_first  = VECS[k].lo;
            thr_second = VECS[k].hi;
            feed(12'd0, 30);
            ev_count = 0;
            pulse(VECS[k].s0, VECS[k].s1, VECS[k].tail);
            feed(12'd0, 30);
            check(ev_count == (VECS[k].hit ? 1 : 0), VECS[k].hit ? "R2" : "R3",
                  $sformatf("vector %0d event count", k), ev_count, VECS[k].hit);
            if (VECS[k].hit)
                check(ev_last == {VECS[k].area, 4'd0, VECS[k].s0}, "R1/R5",
                      $sformatf("vector %0d record", k), ev_last,
                      {VECS[k].area, 4'd0, VECS[k].s0});
        end

        // R6 R7: stalled consumer across two pulses
        thr_first = 12'd20; thr_second = 12'd200;
        ev_ready = 1'b0;
        feed(12'd0, 30);
        pulse(12'd40, 12'd400, 12'd1);
        feed(12'd0, 30);
        check(ev_valid && ev_data == {16'd463, 16'd40}, "R6", "held record",
              ev_data, {16'd463, 16'd40});
        check(!ev_overflow, "R7", "no overflow yet", ev_overflow, 0);
        pulse(12'd60, 12'd600, 12'd2);
        feed(12'd0, 30);
        check(ev_valid && ev_data == {16'd463, 16'd40}, "R7", "first record kept",
              ev_data, {16'd463, 16'd40});
        check(ev_overflow, "R7", "overflow set", ev_overflow, 1);
        ev_ready = 1'b1;
        @(negedge clk);
        check(!ev_valid, "R6", "valid drops after accept", ev_valid, 0);
        feed(12'd0, 5);
        check(ev_overflow, "R7", "overflow sticky", ev_overflow, 1);

        // R8 R9 R4: reset clears window, fill timing, hold spacing
        thr_first = 12'd4095; thr_second = 12'd4095;
        feed(12'd4095, 30);
        rst = 1'b1;
        thr_first = 12'd0; thr_second = 12'd0;
        smp_in = 12'd0;
        @(negedge clk);
        @(negedge clk);
        check(!ev_valid && !ev_overflow, "R8", "reset clears flags",
              {30'd0, ev_valid, ev_overflow}, 32'd0);
        rst = 1'b0;
        begin
            int first_at;
            int second_at;
            first_at = 0;
            second_at = 0;
            for (int c = 1; c <= 60; c++) begin
                @(negedge clk);
                if (ev_valid && first_at == 0) first_at = c;
                else if (ev_valid && second_at == 0) second_at = c;
                if (c == 26)
                    check(ev_data == 32'd0, "R8", "area after reset", ev_data, 0);
            end
            check(first_at == 26, "R9", "first record cycle", first_at, 26);
            check(second_at - first_at == 25, "R4", "record spacing",
                  second_at - first_at, 25);
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule